// File: doc/BRIEF.md
# Graphics DRAM Command Decoder

This block sits at the command interface of a two-bank synchronous graphics DRAM. On every rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable together with a special-function select, and turns each accepted combination into a one-cycle command strobe. It tracks whether each bank has an open row and whether that row was opened in masked-write mode. It also latches the row, column and bank addresses that go with each command.

The block holds the operating mode: CAS latency, burst length code and burst ordering. It also raises the strobes that load the bit-mask register or the color register when a register-set command carries the special-function flag. A read or write aimed at a closed bank is reported and dropped. A clock-enable input freezes decoding from the cycle after it is sampled low. The cell array, refresh timing and data path lie outside this block.

Top module: `sgram_cmd_decoder`

## Requirements
- R1: Commands are sampled on the rising edge. The encoding over {csN,rasN,casN,weN} is: 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 0000 register set. A command's strobe is high for exactly the one cycle that follows its sampling edge, and at most one command strobe is high at a time.
- R2: While csN is high, the command lines, dsf and the address have no effect: no strobe fires and no latched state changes.
- R3: Activate latches addr[9:0] as the row and bankSel as the bank, and marks that bank open. It marks the bank masked-write if dsf is high and clears that mark otherwise.
- R4: A read or write to an open bank latches addr[7:0] as the column and bankSel as the bank. A write with dsf high also raises blockWrite. A write with dsf low to a masked-write bank also raises writeMasked.
- R5: A read or write to a bank with no open row raises illegalCmd, gives no read or write strobe, and leaves the column and bank latches unchanged.
- R6: Precharge with addr[9] low closes the bank given by bankSel. With addr[9] high it closes both banks. Closing a bank clears its masked-write mark.
- R7: A register set with dsf low raises cmdMrs and programs the mode. addr[6:4] is the CAS latency (010 gives 2, 011 gives 3). addr[3] is the burst ordering (1 interleaved). addr[2:0] is the burst length code (000 one, 001 two, 010 four, 011 eight, 111 full page), output unchanged on burstCode.
- R8: A reserved CAS latency or burst length code in a register set leaves that field at its previous value. The other fields still update.
- R9: A register set with dsf high leaves the mode unchanged. It raises loadColor when addr[5] is high and loadMask when addr[5] is low.
- R10: When clkEn is low at one rising edge, the command sampled at the following edge is ignored completely.
- R11: After reset no strobe is high, both banks are closed and unmasked, the latches are zero, the CAS latency is 3, and the burst is sequential with length code 000.
- R12: Refresh raises cmdRef and changes no bank or mode state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable; low freezes the next edge |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | 10 | Multiplexed row/column/mode address |
| bankSel | input | 1 | Bank select address |
| cmdAct | output | 1 | Activate accepted |
| cmdRead | output | 1 | Read accepted |
| cmdWrite | output | 1 | Write accepted |
| cmdPre | output | 1 | Precharge accepted |
| cmdRef | output | 1 | Refresh accepted |
| cmdMrs | output | 1 | Mode register programmed |
| loadMask | output | 1 | Mask register load |
| loadColor | output | 1 | Color register load |
| illegalCmd | output | 1 | Read/write to closed bank dropped |
| writeMasked | output | 1 | Accepted write uses the bit mask |
| blockWrite | output | 1 | Accepted write is a block write |
| bankOpen | output | 2 | Per-bank open-row flags |
| bankMasked | output | 2 | Per-bank masked-write flags |
| rowAddr | output | 10 | Latched row address |
| colAddr | output | 8 | Latched column address |
| bankAddr | output | 1 | Latched bank of last access |
| casLatency | output | 2 | Programmed CAS latency |
| burstCode | output | 3 | Programmed burst length code |
| burstInterleave | output | 1 | Burst ordering, 1 interleaved |

## Verification
On every cycle the assertions check the following. At most one command strobe is high. No strobe follows a frozen edge. An accepted read or write always names an open bank. A dropped access leaves the column latch alone. The programmed latency and burst code always stay legal and change only alongside a mode-set strobe. The directed scenarios show what no per-cycle property can: that each encoding yields the right strobe and latched values, that reserved fields are skipped while the other fields still update, that deselected and frozen commands leave the state alone, and that the masked-write and block-write qualifiers follow the activate and write flags.

// File: rtl/sgram_cmd_pkg.sv
package sgram_cmd_pkg;
  localparam int ROW_W  = 10;
  localparam int COL_W  = 8;
  localparam int BANKS  = 2;
  localparam int BANK_W = $clog2(BANKS);

  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111
  } cmdCode_t;

  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic ref_;
    logic mrs;
    logic ldMask;
    logic ldColor;
    logic illegal;
    logic wrMasked;
    logic wrBlock;
  } cmdStrobe_t;
endpackage

// File: rtl/sgram_cmd_ctrl.sv
module sgram_cmd_ctrl
  import sgram_cmd_pkg::*;
#(
  parameter int BANK_CNT = BANKS,
  parameter int BSEL_W   = BANK_W,
  parameter int ADDR_W   = ROW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clkEn,
  input  logic                csN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                dsf,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BSEL_W-1:0]   bankSel,
  output cmdStrobe_t          strobeNow,
  output cmdStrobe_t          strobeQ,
  output logic [BANK_CNT-1:0] bankOpen,
  output logic [BANK_CNT-1:0] bankMasked
);
  localparam int PRE_ALL_BIT = ADDR_W - 1;
  localparam int REG_SEL_BIT = 5;

  logic       ckePrev;
  logic [3:0] cmdLines;
  logic       edgeLive;
  logic       targetOpen;

  assign cmdLines   = {csN, rasN, casN, weN};
  assign edgeLive   = ckePrev && !csN;
  assign targetOpen = bankOpen[bankSel];

  always_comb begin
    strobeNow = '0;
    if (edgeLive) begin
      unique case (cmdLines)
        CMD_ACT: strobeNow.act = 1'b1;
        CMD_RD: begin
          strobeNow.rd      = targetOpen;
          strobeNow.illegal = !targetOpen;
        end
        CMD_WR: begin
          strobeNow.wr       = targetOpen;
          strobeNow.illegal  = !targetOpen;
          strobeNow.wrBlock  = targetOpen && dsf;
          strobeNow.wrMasked = targetOpen && !dsf && bankMasked[bankSel];
        end
        CMD_PRE: strobeNow.pre  = 1'b1;
        CMD_REF: strobeNow.ref_ = 1'b1;
        CMD_MRS: begin
          strobeNow.mrs     = !dsf;
          strobeNow.ldColor = dsf && addr[REG_SEL_BIT];
          strobeNow.ldMask  = dsf && !addr[REG_SEL_BIT];
        end
        default: strobeNow = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckePrev <= 1'b1;
      strobeQ <= '0;
    end else begin
      ckePrev <= clkEn;
      strobeQ <= strobeNow;
    end
  end

  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic hitAct;
    logic hitPre;
    assign hitAct = strobeNow.act && (bankSel == BSEL_W'(b));
    assign hitPre = strobeNow.pre && (addr[PRE_ALL_BIT] || (bankSel == BSEL_W'(b)));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[b]   <= 1'b0;
        bankMasked[b] <= 1'b0;
      end else if (hitAct) begin
        bankOpen[b]   <= 1'b1;
        bankMasked[b] <= dsf;
      end else if (hitPre) begin
        bankOpen[b]   <= 1'b0;
        bankMasked[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sgram_cmd_datapath.sv
module sgram_cmd_datapath
  import sgram_cmd_pkg::*;
#(
  parameter int RW     = ROW_W,
  parameter int CW     = COL_W,
  parameter int BSEL_W = BANK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobeNow,
  input  logic [RW-1:0]     addr,
  input  logic [BSEL_W-1:0] bankSel,
  output logic [RW-1:0]     rowAddr,
  output logic [CW-1:0]     colAddr,
  output logic [BSEL_W-1:0] bankAddr,
  output logic [1:0]        casLatency,
  output logic [2:0]        burstCode,
  output logic              burstInterleave
);
  logic [2:0] latField;
  logic [2:0] lenField;
  logic       latOk;
  logic       lenOk;

  assign latField = addr[6:4];
  assign lenField = addr[2:0];
  assign latOk    = (latField == 3'b010) || (latField == 3'b011);
  assign lenOk    = (lenField[2] == 1'b0) || (lenField == 3'b111);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowAddr  <= '0;
      colAddr  <= '0;
      bankAddr <= '0;
    end else begin
      if (strobeNow.act) begin
        rowAddr  <= addr;
        bankAddr <= bankSel;
      end
      if (strobeNow.rd || strobeNow.wr) begin
        colAddr  <= addr[CW-1:0];
        bankAddr <= bankSel;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      casLatency      <= 2'd3;
      burstCode       <= 3'b000;
      burstInterleave <= 1'b0;
    end else if (strobeNow.mrs) begin
      burstInterleave <= addr[3];
      if (latOk) casLatency <= latField[1:0];
      if (lenOk) burstCode  <= lenField;
    end
  end
endmodule

// File: rtl/sgram_cmd_decoder.sv
module sgram_cmd_decoder
  import sgram_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              dsf,
  input  logic [ROW_W-1:0]  addr,
  input  logic [BANK_W-1:0] bankSel,
  output logic              cmdAct,
  output logic              cmdRead,
  output logic              cmdWrite,
  output logic              cmdPre,
  output logic              cmdRef,
  output logic              cmdMrs,
  output logic              loadMask,
  output logic              loadColor,
  output logic              illegalCmd,
  output logic              writeMasked,
  output logic              blockWrite,
  output logic [BANKS-1:0]  bankOpen,
  output logic [BANKS-1:0]  bankMasked,
  output logic [ROW_W-1:0]  rowAddr,
  output logic [COL_W-1:0]  colAddr,
  output logic [BANK_W-1:0] bankAddr,
  output logic [1:0]        casLatency,
  output logic [2:0]        burstCode,
  output logic              burstInterleave
);
  cmdStrobe_t strobeNow;
  cmdStrobe_t strobeQ;

  sgram_cmd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .dsf(dsf), .addr(addr), .bankSel(bankSel),
    .strobeNow(strobeNow), .strobeQ(strobeQ),
    .bankOpen(bankOpen), .bankMasked(bankMasked)
  );

  sgram_cmd_datapath i_datapath (
    .clk(clk), .rstN(rstN), .strobeNow(strobeNow), .addr(addr),
    .bankSel(bankSel), .rowAddr(rowAddr), .colAddr(colAddr),
    .bankAddr(bankAddr), .casLatency(casLatency), .burstCode(burstCode),
    .burstInterleave(burstInterleave)
  );

  assign cmdAct      = strobeQ.act;
  assign cmdRead     = strobeQ.rd;
  assign cmdWrite    = strobeQ.wr;
  assign cmdPre      = strobeQ.pre;
  assign cmdRef      = strobeQ.ref_;
  assign cmdMrs      = strobeQ.mrs;
  assign loadMask    = strobeQ.ldMask;
  assign loadColor   = strobeQ.ldColor;
  assign illegalCmd  = strobeQ.illegal;
  assign writeMasked = strobeQ.wrMasked;
  assign blockWrite  = strobeQ.wrBlock;
endmodule

// File: rtl/sgram_cmd_checker.sv
module sgram_cmd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       clkEn,
  input logic       cmdAct,
  input logic       cmdRead,
  input logic       cmdWrite,
  input logic       cmdPre,
  input logic       cmdRef,
  input logic       cmdMrs,
  input logic       loadMask,
  input logic       loadColor,
  input logic       illegalCmd,
  input logic [1:0] bankOpen,
  input logic [7:0] colAddr,
  input logic       bankAddr,
  input logic [1:0] casLatency,
  input logic [2:0] burstCode
);
  logic [8:0] anyStrobe;
  assign anyStrobe = {cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdMrs,
                      loadMask, loadColor, illegalCmd};

  // R1: command strobes are mutually exclusive
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(anyStrobe));

  // R10: an edge after a low clock enable yields no strobe
  assert_frozen_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(clkEn, 2) && $past(rstN, 2)) |-> (anyStrobe == '0));

  // R4: an accepted access names an open bank
  assert_access_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead || cmdWrite) |-> bankOpen[bankAddr]);

  // R5: a dropped access keeps the column latch
  assert_illegal_keeps_col_R5: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> $stable(colAddr));

  // R8: latency and burst code stay legal
  assert_legal_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (casLatency == 2'd2 || casLatency == 2'd3) && (burstCode[2] == 1'b0 || burstCode == 3'b111));

  // R7: mode changes only with a mode-set strobe
  assert_mode_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    !($stable(casLatency) && $stable(burstCode)) |-> cmdMrs);
endmodule

bind sgram_cmd_decoder sgram_cmd_checker i_checker (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .cmdAct(cmdAct), .cmdRead(cmdRead),
  .cmdWrite(cmdWrite), .cmdPre(cmdPre), .cmdRef(cmdRef), .cmdMrs(cmdMrs),
  .loadMask(loadMask), .loadColor(loadColor), .illegalCmd(illegalCmd),
  .bankOpen(bankOpen), .colAddr(colAddr), .bankAddr(bankAddr),
  .casLatency(casLatency), .burstCode(burstCode)
);

// File: tb/test_sgram_cmd_decoder.sv
module test_sgram_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1;
  logic csN = 1'b0, rasN = 1'b1, casN = 1'b1, weN = 1'b1, dsf = 1'b0;
  logic [9:0] addr = '0;
  logic bankSel = 1'b0;
  logic cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdMrs;
  logic loadMask, loadColor, illegalCmd, writeMasked, blockWrite;
  logic [1:0] bankOpen, bankMasked;
  logic [9:0] rowAddr;
  logic [7:0] colAddr;
  logic bankAddr;
  logic [1:0] casLatency;
  logic [2:0] burstCode;
  logic burstInterleave;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgram_cmd_decoder i_sgram_cmd_decoder (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .dsf(dsf), .addr(addr), .bankSel(bankSel),
    .cmdAct(cmdAct), .cmdRead(cmdRead), .cmdWrite(cmdWrite), .cmdPre(cmdPre),
    .cmdRef(cmdRef), .cmdMrs(cmdMrs), .loadMask(loadMask), .loadColor(loadColor),
    .illegalCmd(illegalCmd), .writeMasked(writeMasked), .blockWrite(blockWrite),
    .bankOpen(bankOpen), .bankMasked(bankMasked), .rowAddr(rowAddr),
    .colAddr(colAddr), .bankAddr(bankAddr), .casLatency(casLatency),
    .burstCode(burstCode), .burstInterleave(burstInterleave)
  );

  function automatic logic [10:0] strobes();
    return {cmdAct, cmdRead, cmdWrite, cmdPre, cmdRef, cmdMrs,
            loadMask, loadColor, illegalCmd, writeMasked, blockWrite};
  endfunction

  // strobe bit positions within strobes()
  localparam logic [10:0] S_ACT = 11'b10000000000;
  localparam logic [10:0] S_RD  = 11'b01000000000;
  localparam logic [10:0] S_WR  = 11'b00100000000;
  localparam logic [10:0] S_PRE = 11'b00010000000;
  localparam logic [10:0] S_REF = 11'b00001000000;
  localparam logic [10:0] S_MRS = 11'b00000100000;
  localparam logic [10:0] S_LM  = 11'b00000010000;
  localparam logic [10:0] S_LC  = 11'b00000001000;
  localparam logic [10:0] S_ILL = 11'b00000000100;
  localparam logic [10:0] S_WM  = 11'b00000000010;
  localparam logic [10:0] S_BW  = 11'b00000000001;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one command for one edge, then return to NOP; ends at the negedge after
  task automatic issue(input logic [3:0] lines, input logic d,
                       input logic [9:0] a, input logic b);
    {csN, rasN, casN, weN} = lines;
    dsf = d; addr = a; bankSel = b;
    @(posedge clk); #1;
    {csN, rasN, casN, weN} = 4'b0111;
    dsf = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R11", "strobes", 32'(strobes()), 32'h0);
    check("R11", "bankOpen", 32'(bankOpen), 32'h0);
    check("R11", "bankMasked", 32'(bankMasked), 32'h0);
    check("R11", "latches", {rowAddr, colAddr, 13'd0, bankAddr}, 32'h0);
    check("R11", "mode", {casLatency, burstCode, burstInterleave}, {2'd3, 3'b000, 1'b0});
  endtask

  task automatic testModeSet();
    issue(4'b0000, 1'b0, 10'h02B, 1'b0);
    check("R7", "strobe", 32'(strobes()), 32'(S_MRS));
    check("R7", "mode", {casLatency, burstCode, burstInterleave}, {2'd2, 3'b011, 1'b1});
    @(negedge clk);
    check("R1", "strobe one cycle", 32'(strobes()), 32'h0);
    issue(4'b0000, 1'b0, 10'h037, 1'b0);
    check("R7", "full page", {casLatency, burstCode, burstInterleave}, {2'd3, 3'b111, 1'b0});
  endtask

  task automatic testReserved();
    issue(4'b0000, 1'b0, 10'h02B, 1'b0);
    issue(4'b0000, 1'b0, 10'h054, 1'b0);
    check("R8", "reserved kept", {casLatency, burstCode, burstInterleave}, {2'd2, 3'b011, 1'b0});
  endtask

  task automatic testIllegal();
    issue(4'b0101, 1'b0, 10'h0AA, 1'b0);
    check("R5", "strobe", 32'(strobes()), 32'(S_ILL));
    check("R5", "col kept", 32'(colAddr), 32'h0);
    issue(4'b0100, 1'b1, 10'h0BB, 1'b1);
    check("R5", "write closed", 32'(strobes()), 32'(S_ILL));
  endtask

  task automatic testActRead();
    issue(4'b0011, 1'b0, 10'h2A5, 1'b1);
    check("R3", "strobe", 32'(strobes()), 32'(S_ACT));
    check("R3", "row/bank", {rowAddr, bankAddr}, {10'h2A5, 1'b1});
    check("R3", "open", {bankOpen, bankMasked}, {2'b10, 2'b00});
    issue(4'b0101, 1'b0, 10'h35C, 1'b1);
    check("R4", "read", 32'(strobes()), 32'(S_RD));
    check("R4", "col", {colAddr, bankAddr}, {8'h5C, 1'b1});
    issue(4'b0100, 1'b1, 10'h011, 1'b1);
    check("R4", "block write", 32'(strobes()), 32'(S_WR | S_BW));
    check("R4", "write col", 32'(colAddr), 32'h11);
  endtask

  task automatic testMaskedWrite();
    issue(4'b0011, 1'b1, 10'h001, 1'b0);
    check("R3", "masked mark", {bankOpen, bankMasked}, {2'b11, 2'b01});
    issue(4'b0100, 1'b0, 10'h022, 1'b0);
    check("R4", "masked write", 32'(strobes()), 32'(S_WR | S_WM));
    issue(4'b0100, 1'b0, 10'h023, 1'b1);
    check("R4", "plain write", 32'(strobes()), 32'(S_WR));
  endtask

  task automatic testSpecialLoad();
    issue(4'b0000, 1'b1, 10'h020, 1'b0);
    check("R9", "color", 32'(strobes()), 32'(S_LC));
    check("R9", "mode kept", {casLatency, burstCode, burstInterleave}, {2'd2, 3'b011, 1'b0});
    issue(4'b0000, 1'b1, 10'h013, 1'b0);
    check("R9", "mask", 32'(strobes()), 32'(S_LM));
  endtask

  task automatic testDeselect();
    issue(4'b1011, 1'b0, 10'h3FF, 1'b0);
    check("R2", "no strobe", 32'(strobes()), 32'h0);
    check("R2", "state kept", {rowAddr, bankOpen}, {10'h001, 2'b11});
    issue(4'b1000, 1'b0, 10'h07F, 1'b0);
    check("R2", "mode kept", {cmdMrs, casLatency, burstCode}, {1'b0, 2'd2, 3'b011});
  endtask

  task automatic testRefresh();
    issue(4'b0001, 1'b0, 10'h000, 1'b0);
    check("R12", "strobe", 32'(strobes()), 32'(S_REF));
    check("R12", "banks kept", {bankOpen, bankMasked}, {2'b11, 2'b01});
  endtask

  task automatic testPrecharge();
    issue(4'b0010, 1'b0, 10'h000, 1'b1);
    check("R6", "single", {strobes(), bankOpen, bankMasked}, {S_PRE, 2'b01, 2'b01});
    issue(4'b0011, 1'b0, 10'h0F0, 1'b1);
    issue(4'b0010, 1'b0, 10'h200, 1'b0);
    check("R6", "all", {bankOpen, bankMasked}, {2'b00, 2'b00});
  endtask

  task automatic testFreeze();
    clkEn = 1'b0;
    @(posedge clk); #1;
    clkEn = 1'b1;
    @(negedge clk);
    issue(4'b0011, 1'b0, 10'h155, 1'b0);
    check("R10", "no strobe", 32'(strobes()), 32'h0);
    check("R10", "state kept", {bankOpen, rowAddr}, {2'b00, 10'h0F0});
    issue(4'b0011, 1'b0, 10'h155, 1'b0);
    check("R10", "resumed", {strobes(), bankOpen}, {S_ACT, 2'b01});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testModeSet();
        testReserved();
        testIllegal();
        testActRead();
        testMaskedWrite();
        testSpecialLoad();
        testDeselect();
        testRefresh();
        testPrecharge();
        testFreeze();
      end
      begin
        repeat (5000) @(posedge clk);
        testsRun++;
        testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule